// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the control engine of a transmit DMA path. It walks a linked list of four-word descriptors kept in system memory. For each descriptor it fetches the words through a word-wide request/response memory port. It then confirms that hardware owns the descriptor and passes the buffer address and frame length to a packet-streaming stage through a request/done handshake. When the stage reports the result, the engine writes the completion status back into the descriptor and follows the next-descriptor pointer.

Software fills descriptors and hands them over by setting the owner flag. It enables the engine with `tx_on`, which also loads the list start address into the current-descriptor register. Nothing is sent until software pulses `poll`. The engine then runs descriptor after descriptor until it reaches one that software still owns, and halts there. A later poll resumes from that same descriptor. Completion, descriptor-unavailable and bus-error conditions leave the block as single-cycle event pulses for an interrupt controller.

Top module: `tx_desc_walker`

## Requirements
- R1: A descriptor at byte address D occupies four words. D+0 holds the flags, D+4 the buffer address, D+8 the status/length word (frame length in bits 15:0), and D+12 the next-descriptor address. The engine reads them in that order.
- R2: A rising edge on `tx_on` loads `cur_desc` from `list_base` with bits 1:0 forced to zero. No memory request is issued until `poll` is pulsed.
- R3: A `poll` pulse while `tx_on` is high starts the engine, and it processes descriptors one after another. On reading a flags word with bit 31 (owner) clear, it pulses `ev_unavail`, returns to idle and leaves `cur_desc` pointing at that descriptor.
- R4: For an owned descriptor, `send_req` rises with `send_addr` equal to the buffer address. `send_len` equals the length field. If flags bit 0 (pad enable) is set and the length is below 64, `send_len` is 64 instead. Both are held until `send_done`.
- R5: Write-back rewrites the flags word with bit 31 cleared and all other bits kept. It also rewrites the status/length word with bits 31:16 cleared except bit 19, which is set on success, and bits 15:0 kept. Words D+4 and D+12 are not written.
- R6: `ev_done` pulses after write-back only when the send succeeded and flags bit 2 (interrupt enable) is set.
- R7: A memory error on any descriptor read pulses `ev_buserr` and stops the engine. Nothing is written back and `cur_desc` is unchanged.
- R8: A send that finishes with `send_err` pulses `ev_buserr` and gives no `ev_done`. The descriptor is still written back with the owner bit cleared and bit 19 clear, and the engine advances to the next descriptor.
- R9: After write-back, `cur_desc` takes the next-descriptor address with bits 1:0 cleared. `cur_buf` shows the buffer address of the descriptor in use.
- R10: While `tx_on` is low the engine is idle from the next cycle on, with `mem_req` and `send_req` low, and `poll` has no effect. A falling edge of `tx_on` sets `halted`, which stays set until `halt_clr` is pulsed.
- R11: `mem_req` keeps its address until `mem_ack` while `tx_on` stays high. `mem_req` and `send_req` are never high together, and at most one event pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_on | input | 1 | Transmit enable level |
| poll | input | 1 | Poll-demand strobe |
| list_base | input | 32 | Descriptor list start byte address |
| halt_clr | input | 1 | Clears the halted flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response strobe |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| send_req | output | 1 | Frame send request |
| send_addr | output | 32 | Buffer start address |
| send_len | output | 16 | Frame length after padding |
| send_done | input | 1 | Send finished |
| send_err | input | 1 | Buffer read failed, valid with send_done |
| cur_desc | output | 32 | Current descriptor address |
| cur_buf | output | 32 | Current buffer address |
| running | output | 1 | Engine is walking the list |
| halted | output | 1 | Sticky transmit-halted flag |
| ev_done | output | 1 | Transmit-complete event pulse |
| ev_unavail | output | 1 | Descriptor-unavailable event pulse |
| ev_buserr | output | 1 | Bus-error event pulse |

## Verification
The hardest case to reach is a fault that sits inside a chain that is otherwise working. In one case the buffer fails while the descriptor is owned and has interrupts enabled. In the other a descriptor read fails after earlier descriptors succeeded. The bench builds a 24-entry ring that sweeps frame length, padding and interrupt enable, and ends it with a software-owned entry. It then reuses that stop point, hands the entry over, and chains a descriptor whose buffer address the send model rejects. The next descriptor's flags word is marked faulty in the memory model, so resumption, error write-back and the halt without advance are each reached by separate polls.

// File: rtl/tx_desc_walker.sv
module tx_desc_walker #(
  parameter int MIN_FRAME = 64,
  parameter int OWN_BIT   = 31,
  parameter int PAD_BIT   = 0,
  parameter int IE_BIT    = 2,
  parameter int DONE_BIT  = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_on,
  input  logic        poll,
  input  logic [31:0] list_base,
  input  logic        halt_clr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        send_req,
  output logic [31:0] send_addr,
  output logic [15:0] send_len,
  input  logic        send_done,
  input  logic        send_err,
  output logic [31:0] cur_desc,
  output logic [31:0] cur_buf,
  output logic        running,
  output logic        halted,
  output logic        ev_done,
  output logic        ev_unavail,
  output logic        ev_buserr
);

  localparam logic [31:0] WMASK = 32'hFFFF_FFFC;
  localparam logic [15:0] MINL  = 16'(MIN_FRAME);

  typedef enum logic [3:0] {
    S_IDLE, S_FLG, S_BUF, S_LEN, S_NXT, S_SEND, S_WFLG, S_WSTA
  } st_t;

  st_t         st;
  logic        tx_on_q;
  logic        ok;
  logic [31:0] flg;
  logic [15:0] len;
  logic [31:0] nxt;
  logic [31:0] wsta;

  assign running   = (st != S_IDLE);
  assign mem_req   = (st == S_FLG) || (st == S_BUF) || (st == S_LEN) ||
                     (st == S_NXT) || (st == S_WFLG) || (st == S_WSTA);
  assign mem_we    = (st == S_WFLG) || (st == S_WSTA);
  assign send_req  = (st == S_SEND);
  assign send_addr = cur_buf;
  assign send_len  = (flg[PAD_BIT] && (len < MINL)) ? MINL : len;

  always_comb begin
    case (st)
      S_BUF:   mem_addr = cur_desc + 32'd4;
      S_LEN:   mem_addr = cur_desc + 32'd8;
      S_NXT:   mem_addr = cur_desc + 32'd12;
      S_WSTA:  mem_addr = cur_desc + 32'd8;
      default: mem_addr = cur_desc;
    endcase
  end

  always_comb begin
    wsta = {16'h0000, len};
    wsta[DONE_BIT] = ok;
  end

  always_comb begin
    mem_wdata = (st == S_WSTA) ? wsta : flg;
    if (st == S_WFLG) mem_wdata[OWN_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tx_on_q    <= 1'b0;
      ok         <= 1'b0;
      flg        <= '0;
      len        <= '0;
      nxt        <= '0;
      cur_desc   <= '0;
      cur_buf    <= '0;
      halted     <= 1'b0;
      ev_done    <= 1'b0;
      ev_unavail <= 1'b0;
      ev_buserr  <= 1'b0;
    end else begin
      tx_on_q    <= tx_on;
      ev_done    <= 1'b0;
      ev_unavail <= 1'b0;
      ev_buserr  <= 1'b0;
      if (!tx_on && tx_on_q) halted <= 1'b1;
      else if (halt_clr)     halted <= 1'b0;

      if (!tx_on) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (!tx_on_q) cur_desc <= list_base & WMASK;
            if (poll) st <= S_FLG;
          end
          S_FLG: if (mem_ack) begin
            if (mem_err) begin
              ev_buserr <= 1'b1;
              st <= S_IDLE;
            end else if (!mem_rdata[OWN_BIT]) begin
              ev_unavail <= 1'b1;
              st <= S_IDLE;
            end else begin
              flg <= mem_rdata;
              st  <= S_BUF;
            end
          end
          S_BUF: if (mem_ack) begin
            if (mem_err) begin
              ev_buserr <= 1'b1;
              st <= S_IDLE;
            end else begin
              cur_buf <= mem_rdata;
              st <= S_LEN;
            end
          end
          S_LEN: if (mem_ack) begin
            if (mem_err) begin
              ev_buserr <= 1'b1;
              st <= S_IDLE;
            end else begin
              len <= mem_rdata[15:0];
              st  <= S_NXT;
            end
          end
          S_NXT: if (mem_ack) begin
            if (mem_err) begin
              ev_buserr <= 1'b1;
              st <= S_IDLE;
            end else begin
              nxt <= mem_rdata;
              st  <= S_SEND;
            end
          end
          S_SEND: if (send_done) begin
            ok <= !send_err;
            if (send_err) ev_buserr <= 1'b1;
            st <= S_WFLG;
          end
          S_WFLG: if (mem_ack) begin
            if (mem_err) ev_buserr <= 1'b1;
            st <= S_WSTA;
          end
          S_WSTA: if (mem_ack) begin
            if (mem_err) ev_buserr <= 1'b1;
            else if (ok && flg[IE_BIT]) ev_done <= 1'b1;
            cur_desc <= nxt & WMASK;
            st <= S_FLG;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tx_desc_walker_chk.sv
module tx_desc_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_on,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        send_req,
  input logic        send_done,
  input logic [31:0] send_addr,
  input logic [15:0] send_len,
  input logic        halted,
  input logic        ev_done,
  input logic        ev_unavail,
  input logic        ev_buserr
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && tx_on) |=> (mem_req && $stable(mem_addr)));

  // R4
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && !send_done && tx_on) |=> (send_req && $stable(send_addr) && $stable(send_len)));

  // R11
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, send_req}));

  // R11
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_unavail, ev_buserr}));

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> (!mem_req && !send_req));

  // R10
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_on) |=> halted);

endmodule

bind tx_desc_walker tx_desc_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .send_req(send_req), .send_done(send_done),
  .send_addr(send_addr), .send_len(send_len), .halted(halted),
  .ev_done(ev_done), .ev_unavail(ev_unavail), .ev_buserr(ev_buserr)
);

// File: tb/tb_tx_desc_walker.sv
`timescale 1ns/1ps
module tb_tx_desc_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tx_on = 1'b0, poll = 1'b0, halt_clr = 1'b0;
  logic [31:0] list_base = '0;
  logic mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic send_req, send_done = 1'b0, send_err = 1'b0;
  logic [31:0] send_addr, cur_desc, cur_buf;
  logic [15:0] send_len;
  logic running, halted, ev_done, ev_unavail, ev_buserr;

  tx_desc_walker dut (.*);

  localparam logic [31:0] BADBUF = 32'h000B_AD00;
  localparam int DB = 16;

  logic [31:0] mem [0:255];
  logic [255:0] errmap = '0;
  logic pk_en = 1'b0;
  logic [7:0] pk_i = '0;
  logic [31:0] pk_d = '0;

  always @(posedge clk) begin
    if (pk_en) mem[pk_i] <= pk_d;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      mem_err   <= errmap[mem_addr[9:2]];
      if (mem_we && !errmap[mem_addr[9:2]]) mem[mem_addr[9:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  logic [31:0] lg_a [0:63];
  logic [15:0] lg_l [0:63];
  int nsend = 0;
  always @(posedge clk) begin
    if (send_req && !send_done) begin
      send_done <= 1'b1;
      send_err  <= (send_addr == BADBUF);
      lg_a[nsend] <= send_addr;
      lg_l[nsend] <= send_len;
      nsend <= nsend + 1;
    end else begin
      send_done <= 1'b0;
      send_err  <= 1'b0;
    end
  end

  int n_done = 0, n_unav = 0, n_berr = 0, n_req = 0;
  always @(posedge clk) begin
    if (ev_done)    n_done <= n_done + 1;
    if (ev_unavail) n_unav <= n_unav + 1;
    if (ev_buserr)  n_berr <= n_berr + 1;
    if (mem_req)    n_req  <= n_req + 1;
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    @(negedge clk); pk_en = 1'b1; pk_i = 8'(idx); pk_d = v;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    while (running) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int lenof(int k);
    case (k)
      0: return 1; 1: return 20; 2: return 63; 3: return 64; 4: return 65;
      default: return 1500;
    endcase
  endfunction

  function automatic logic [31:0] daddr(int i);
    return 32'h40 + 32'(16 * i);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b_unav, b_berr, b_done, b_send, b_req;
    for (int w = 0; w < 256; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !send_req && !running && !halted, "reset", {28'h0, mem_req, send_req, running, halted}, 0);
    chk(cur_desc == 0 && !ev_done && !ev_unavail && !ev_buserr, "reset", cur_desc, 0);
    rst_n = 1'b1;

    // ring of 24 owned descriptors, then a software-owned one
    for (int i = 0; i < 24; i++) begin
      poke(DB + 4*i,     32'h8000_0020 | 32'((i/6)%2) | (32'((i/12)%2) << 2));
      poke(DB + 4*i + 1, 32'h1000 + 32'(i * 256));
      poke(DB + 4*i + 2, 32'hABCD_0000 | 32'(lenof(i%6)));
      poke(DB + 4*i + 3, daddr(i+1) | 32'h3);
    end
    poke(DB + 96,  32'h0000_0004);
    poke(DB + 97,  32'h1000 + 32'(24 * 256));
    poke(DB + 98,  32'h0000_0030);
    poke(DB + 99,  daddr(25));

    // R2: enable loads start address, no access before poll
    @(negedge clk); list_base = 32'h43; tx_on = 1'b1;
    repeat (6) @(negedge clk);
    chk(cur_desc == 32'h40, "R2 cur_desc load", cur_desc, 32'h40);
    chk(n_req == 0, "R2 no request before poll", n_req, 0);

    // R3 R4 R5 R6 R9: sweep
    do_poll();
    chk(nsend == 24, "R3 sends until sw owned", nsend, 24);
    chk(n_unav == 1, "R3 unavailable event", n_unav, 1);
    chk(n_done == 12, "R6 done events only with ie", n_done, 12);
    chk(n_berr == 0, "R8 no bus error", n_berr, 0);
    chk(cur_desc == daddr(24), "R3 R9 stops at sw desc", cur_desc, daddr(24));
    for (int i = 0; i < 24; i++) begin
      logic [31:0] ef, es, el;
      ef = 32'h0000_0020 | 32'((i/6)%2) | (32'((i/12)%2) << 2);
      es = 32'h0008_0000 | 32'(lenof(i%6));
      el = (((i/6)%2) == 1 && lenof(i%6) < 64) ? 32'd64 : 32'(lenof(i%6));
      chk(lg_a[i] == 32'h1000 + 32'(i*256), "R1 R4 send address", lg_a[i], 32'h1000 + 32'(i*256));
      chk(32'(lg_l[i]) == el, "R4 send length", 32'(lg_l[i]), el);
      chk(mem[DB + 4*i] == ef, "R5 flags write-back", mem[DB + 4*i], ef);
      chk(mem[DB + 4*i + 2] == es, "R5 status write-back", mem[DB + 4*i + 2], es);
      chk(mem[DB + 4*i + 3] == (daddr(i+1) | 32'h3), "R5 next untouched", mem[DB + 4*i + 3], daddr(i+1) | 32'h3);
    end

    // R3: poll again, still sw-owned
    b_send = nsend;
    do_poll();
    chk(nsend == b_send && n_unav == 2, "R3 repoll halts", nsend, b_send);
    chk(cur_desc == daddr(24), "R3 cur_desc kept", cur_desc, daddr(24));

    // R9: resume after handing over
    poke(DB + 99 + 1, 32'h0);
    poke(DB + 96, 32'h8000_0004);
    do_poll();
    chk(nsend == b_send + 1, "R3 resumed one send", nsend, b_send + 1);
    chk(cur_buf == 32'h1000 + 32'(24*256), "R9 cur_buf", cur_buf, 32'h1000 + 32'(24*256));
    chk(cur_desc == daddr(25), "R9 cur_desc next", cur_desc, daddr(25));

    // R8: buffer error
    b_done = n_done; b_berr = n_berr; b_unav = n_unav;
    poke(DB + 101, BADBUF);
    poke(DB + 102, 32'hFFFF_0010);
    poke(DB + 103, daddr(26));
    poke(DB + 104, 32'h0);
    poke(DB + 100, 32'h8000_0004);
    do_poll();
    chk(n_berr == b_berr + 1, "R8 bus error event", n_berr, b_berr + 1);
    chk(n_done == b_done, "R8 no done event", n_done, b_done);
    chk(mem[DB + 100] == 32'h4, "R8 owner cleared", mem[DB + 100], 32'h4);
    chk(mem[DB + 102] == 32'h10, "R8 status no done bit", mem[DB + 102], 32'h10);
    chk(cur_desc == daddr(26) && n_unav == b_unav + 1, "R8 advanced", cur_desc, daddr(26));

    // R7: descriptor read error
    b_berr = n_berr; b_unav = n_unav; b_send = nsend;
    errmap[DB + 104] = 1'b1;
    poke(DB + 104, 32'h8000_0000);
    do_poll();
    chk(n_berr == b_berr + 1, "R7 bus error event", n_berr, b_berr + 1);
    chk(n_unav == b_unav && nsend == b_send, "R7 halted no send", nsend, b_send);
    chk(cur_desc == daddr(26), "R7 cur_desc kept", cur_desc, daddr(26));
    chk(mem[DB + 104] == 32'h8000_0000, "R7 no write-back", mem[DB + 104], 32'h8000_0000);
    errmap[DB + 104] = 1'b0;

    // R10: abort mid run, halted flag, poll ignored, re-enable
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    @(negedge clk); tx_on = 1'b0;
    @(negedge clk);
    chk(!mem_req && !send_req && !running, "R10 abort idle", {29'h0, mem_req, send_req, running}, 0);
    chk(halted, "R10 halted set", halted, 1);
    b_req = n_req;
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_req == b_req, "R10 poll ignored while off", n_req, b_req);
    chk(halted, "R10 halted sticky", halted, 1);
    halt_clr = 1'b1;
    @(negedge clk); halt_clr = 1'b0;
    @(negedge clk);
    chk(!halted, "R10 halted cleared", halted, 0);
    list_base = 32'h200; tx_on = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(cur_desc == 32'h200, "R2 reload on re-enable", cur_desc, 32'h200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule